// File: doc/BRIEF.md
# I2C Target Read Responder

This block is an I2C bus target that serves read requests from a master using bytes supplied by local logic. It samples the SCL and SDA wires through synchronizers and detects start and stop conditions at any point in a transfer. After a start it collects the address byte and compares its upper seven bits with a configured own-address input. It then either acknowledges the read and streams data bytes out MSB first, or leaves the bus alone. SDA is modelled as open drain. The single output `sda_oe` pulls the line low when it is 1. The block never drives SCL and never stretches the clock.

Data bytes come from a ready/valid source. The block asserts `tx_rdy` for one cycle per byte, one bit-time before that byte's MSB is needed. `tx_last` marks the final byte of a prepared buffer. A level input `tx_ready` states whether data is prepared, and the block samples it only when it decides on the address acknowledge. Three event pulses report a completed buffer, an abort by the master and a read that was declined. Each pulse is gated by its own mask bit.

The FSM has six states. ST_IDLE waits for a start. ST_ADDR shifts in the address byte. ST_AACK drives the address acknowledge. ST_SEND drives eight data bits. ST_MACK samples the master's acknowledge. ST_SKIP releases the bus until the next start. A start moves any state to ST_ADDR, and a stop moves any state to ST_IDLE. On the SCL fall after the eighth address bit, ST_ADDR goes to ST_AACK (match, read, ready) or to ST_SKIP (anything else). ST_AACK goes to ST_SEND on the next SCL fall. ST_SEND goes to ST_MACK on the SCL fall after its eighth bit. ST_MACK goes back to ST_SEND (master ACK, or fill mode) or to ST_SKIP (master NACK).

Top module: `i2c_rd_target`

## Requirements
- R1: While `rst_n` is low, and after its release with the bus idle, `sda_oe`, `tx_rdy` and all three event outputs are 0.
- R2: A start (SDA falling while SCL is high) restarts address collection from any state, including in the middle of a byte. A stop (SDA rising while SCL is high) returns the block to idle, so bits clocked after it without a new start get no response.
- R3: The address byte is sent MSB first, with the address in bits 7..1 and R/W in bit 0 (1 = read). A byte whose address equals `own_addr`, with R/W = 1 and `tx_ready` = 1, is acknowledged: SDA is held low during the ninth SCL clock.
- R4: A byte whose address differs from `own_addr` gets no acknowledge. SDA stays released until the next start, and no event pulses.
- R5: A matching read while `tx_ready` is 0 gets no acknowledge, and `evt_err` pulses once (mask bit 2).
- R6: A matching write (R/W = 0) gets no acknowledge and raises no event.
- R7: Data bytes are sent MSB first, with a 0 bit driven low and a 1 bit released. `sda_oe` changes only while SCL is low.
- R8: `tx_rdy` is a one-cycle pulse. A byte is taken when `tx_rdy` and `tx_valid` are both 1. The first request comes at the address acknowledge decision, and each later one at the SCL fall that ends a data byte. No request is made after a byte flagged `tx_last`.
- R9: If the master answers a buffer byte with NACK, `evt_abort` pulses once (mask bit 1) and SDA stays released until the next start.
- R10: When a byte flagged `tx_last` is ACKed by the master, `evt_done` pulses once (mask bit 0).
- R11: If no byte is available at a request, or the buffer's last byte has been sent, the block sends 0xFF bytes until a stop. During this fill, master NACKs raise no abort.
- R12: Each event output is a single-cycle pulse and appears only when its bit in `evt_mask` is 1. With the bit at 0 the event is suppressed while bus behaviour is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL wire level |
| sda_i | input | 1 | SDA wire level |
| sda_oe | output | 1 | 1 pulls SDA low |
| own_addr | input | 7 | Configured target address |
| tx_ready | input | 1 | Transmit data prepared (level) |
| tx_data | input | 8 | Byte offered by the source |
| tx_valid | input | 1 | `tx_data` is valid |
| tx_last | input | 1 | Offered byte ends the buffer |
| tx_rdy | output | 1 | Byte request pulse |
| evt_mask | input | 3 | Enables: bit0 done, bit1 abort, bit2 error |
| evt_done | output | 1 | Buffer-complete pulse |
| evt_abort | output | 1 | Master-NACK abort pulse |
| evt_err | output | 1 | Declined-read pulse |

## Verification
Two decisions fall on the same SCL fall at the end of every data byte. One is the request for the next byte. The other is the choice of fill mode when the byte just sent was flagged last or the source has nothing valid. The bench provokes this with buffers that end on a last flag and with a buffer whose source runs dry without a last flag. It judges the result from the bytes read back (real data followed by 0xFF), the number of completed handshakes, and the absence of an abort when the master NACKs a fill byte. A full sweep of all 256 address and R/W values, run with `tx_ready` both low and high, covers the acknowledge and error decision for every address.

// File: rtl/i2c_rd_pkg.sv
package i2c_rd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_SEND,
        ST_MACK,
        ST_SKIP
    } rd_state_t;

    localparam int EV_DONE  = 0;
    localparam int EV_ABORT = 1;
    localparam int EV_ERR   = 2;
    localparam int EV_N     = 3;
endpackage

// File: rtl/i2c_rd_sync.sv
module i2c_rd_sync #(
    parameter int STAGES = 2,
    parameter int LINES  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] din,
    output logic [LINES-1:0] dout
);
    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], din[g]};
        end
        assign dout[g] = chain[STAGES-1];
    end
endmodule

// File: rtl/i2c_rd_cond.sv
module i2c_rd_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_p, sda_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_det = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2c_rd_evt.sv
module i2c_rd_evt #(
    parameter int N = 3
) (
    input  logic [N-1:0] raw,
    input  logic [N-1:0] mask,
    output logic [N-1:0] evt
);
    for (genvar g = 0; g < N; g++) begin : g_gate
        assign evt[g] = raw[g] & mask[g];
    end
endmodule

// File: rtl/i2c_rd_target.sv
module i2c_rd_target
    import i2c_rd_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              tx_ready,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    input  logic              tx_last,
    output logic              tx_rdy,
    input  logic [EV_N-1:0]   evt_mask,
    output logic              evt_done,
    output logic              evt_abort,
    output logic              evt_err
);
    localparam int ABITS = ADDR_W + 1;
    localparam int MAXB  = (DATA_W > ABITS) ? DATA_W : ABITS;
    localparam int CNT_W = $clog2(MAXB + 1);
    localparam logic [CNT_W-1:0] ADDR_END = CNT_W'(ABITS);
    localparam logic [CNT_W-1:0] DATA_END = CNT_W'(DATA_W);

    logic [1:0] line_s;
    logic       scl_s, sda_s;
    logic       scl_rise, scl_fall, start_det, stop_det;

    i2c_rd_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .din({sda_i, scl_i}), .dout(line_s)
    );
    assign scl_s = line_s[0];
    assign sda_s = line_s[1];

    i2c_rd_cond u_cond (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    rd_state_t         st, st_nx;
    logic [ABITS-1:0]  rx_sh;
    logic [DATA_W-1:0] tx_sh, nxt;
    logic [CNT_W-1:0]  cnt;
    logic              cur_last, nxt_last, un_pend, underrun, ack_q;
    logic [EV_N-1:0]   raw_c, raw_q, evt_v;

    logic addr_hit, accept, load_addr, load_tx, load_req, pop_req, reload;

    assign addr_hit  = (rx_sh[ABITS-1:1] == own_addr);
    assign accept    = addr_hit & rx_sh[0] & tx_ready;
    assign load_addr = (st == ST_ADDR) && scl_fall && (cnt == ADDR_END) && accept;
    assign load_tx   = (st == ST_SEND) && scl_fall && (cnt == DATA_END);
    assign load_req  = load_addr | load_tx;
    assign pop_req   = load_addr | (load_tx & ~underrun & ~cur_last);
    assign reload    = scl_fall && ((st == ST_AACK) ||
                       ((st == ST_MACK) && (ack_q || underrun)));

    // raw event conditions, registered into single-cycle pulses
    always_comb begin
        raw_c           = '0;
        raw_c[EV_DONE]  = (st == ST_MACK) && scl_rise && !sda_s && cur_last && !underrun;
        raw_c[EV_ABORT] = (st == ST_MACK) && scl_fall && !ack_q && !underrun;
        raw_c[EV_ERR]   = (st == ST_ADDR) && scl_fall && (cnt == ADDR_END) &&
                          addr_hit && rx_sh[0] && !tx_ready;
    end

    // next-state logic
    always_comb begin
        st_nx = st;
        if (start_det)     st_nx = ST_ADDR;
        else if (stop_det) st_nx = ST_IDLE;
        else begin
            unique case (st)
                ST_IDLE, ST_SKIP: ;
                ST_ADDR: if (scl_fall && cnt == ADDR_END) st_nx = accept ? ST_AACK : ST_SKIP;
                ST_AACK: if (scl_fall) st_nx = ST_SEND;
                ST_SEND: if (scl_fall && cnt == DATA_END) st_nx = ST_MACK;
                ST_MACK: if (scl_fall) st_nx = (ack_q || underrun) ? ST_SEND : ST_SKIP;
                default: st_nx = ST_IDLE;
            endcase
        end
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            rx_sh    <= '0;
            tx_sh    <= '1;
            nxt      <= '1;
            cnt      <= '0;
            cur_last <= 1'b0;
            nxt_last <= 1'b0;
            un_pend  <= 1'b0;
            underrun <= 1'b0;
            ack_q    <= 1'b0;
            raw_q    <= '0;
        end else begin
            st    <= st_nx;
            raw_q <= raw_c;
            if (start_det) begin
                cnt      <= '0;
                cur_last <= 1'b0;
                un_pend  <= 1'b0;
                underrun <= 1'b0;
            end else begin
                if (st == ST_ADDR && scl_rise) begin
                    rx_sh <= {rx_sh[ABITS-2:0], sda_s};
                    cnt   <= cnt + 1'b1;
                end
                if (st == ST_SEND && scl_rise) cnt <= cnt + 1'b1;
                if (st == ST_SEND && scl_fall && cnt != DATA_END)
                    tx_sh <= {tx_sh[DATA_W-2:0], 1'b1};
                if (st == ST_MACK && scl_rise) ack_q <= ~sda_s;
                if (load_req) begin
                    if (pop_req && tx_valid) begin
                        nxt      <= tx_data;
                        nxt_last <= tx_last;
                        un_pend  <= 1'b0;
                    end else begin
                        nxt      <= '1;
                        nxt_last <= 1'b0;
                        un_pend  <= 1'b1;
                    end
                end
                if (reload) begin
                    tx_sh    <= nxt;
                    cur_last <= nxt_last;
                    underrun <= un_pend;
                    cnt      <= '0;
                end
            end
        end
    end

    // outputs
    always_comb begin
        unique case (st)
            ST_AACK: sda_oe = 1'b1;
            ST_SEND: sda_oe = ~tx_sh[DATA_W-1];
            default: sda_oe = 1'b0;
        endcase
    end

    assign tx_rdy = pop_req;

    i2c_rd_evt #(.N(EV_N)) u_evt (.raw(raw_q), .mask(evt_mask), .evt(evt_v));
    assign evt_done  = evt_v[EV_DONE];
    assign evt_abort = evt_v[EV_ABORT];
    assign evt_err   = evt_v[EV_ERR];
endmodule

// File: rtl/i2c_rd_target_chk.sv
module i2c_rd_target_chk
    import i2c_rd_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      scl_s,
    input rd_state_t st,
    input logic      start_det,
    input logic      stop_det,
    input logic      sda_oe,
    input logic      tx_rdy,
    input logic      evt_done,
    input logic      evt_abort,
    input logic      evt_err
);
    assert_oe_scl_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_s);

    assert_start_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (st == ST_ADDR));

    assert_stop_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (st == ST_IDLE));

    assert_pop_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_rdy |=> !tx_rdy);

    assert_evt_onehot_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({evt_done, evt_abort, evt_err}));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        evt_done |=> !evt_done);

    assert_abort_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        evt_abort |=> !evt_abort);
endmodule

bind i2c_rd_target i2c_rd_target_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .st(st),
    .start_det(start_det), .stop_det(stop_det), .sda_oe(sda_oe),
    .tx_rdy(tx_rdy), .evt_done(evt_done), .evt_abort(evt_abort), .evt_err(evt_err)
);

// File: tb/i2c_rd_target_tb.sv
`timescale 1ns/1ps
module i2c_rd_target_tb;
    localparam int Q = 4;
    localparam logic [6:0] OWN = 7'h5A;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1, sda_m = 1'b1;
    logic       sda_oe, tx_rdy, evt_done, evt_abort, evt_err;
    logic       tx_ready = 1'b0, last_en = 1'b1;
    logic [2:0] evt_mask = 3'b111;
    logic [7:0] mem [0:7];
    int         nbytes = 0, idx = 0;
    logic       tx_valid, tx_last, sda_bus;
    logic [7:0] tx_data;

    assign sda_bus  = sda_m & ~sda_oe;
    assign tx_valid = (idx < nbytes);
    assign tx_last  = last_en && (idx == nbytes - 1);
    assign tx_data  = mem[idx[2:0]];

    i2c_rd_target u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
        .own_addr(OWN), .tx_ready(tx_ready), .tx_data(tx_data), .tx_valid(tx_valid),
        .tx_last(tx_last), .tx_rdy(tx_rdy), .evt_mask(evt_mask),
        .evt_done(evt_done), .evt_abort(evt_abort), .evt_err(evt_err)
    );

    int n_chk = 0, n_fail = 0;
    int n_done = 0, n_abort = 0, n_err = 0, n_pop = 0, n_oe_bad = 0;
    logic pop_pend = 1'b0, oe_p = 1'b0;

    always @(negedge clk) begin
        if (evt_done)  n_done++;
        if (evt_abort) n_abort++;
        if (evt_err)   n_err++;
        if (pop_pend) begin idx++; n_pop++; end
        pop_pend = tx_rdy && tx_valid;
        if (sda_oe !== oe_p && scl_m) n_oe_bad++;
        oe_p = sda_oe;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic bitx(input logic b, output logic r);
        sda_m = b; wq(1);
        scl_m = 1'b1; wq(1);
        r = sda_bus; wq(1);
        scl_m = 1'b0; wq(1);
    endtask

    task automatic do_start();
        sda_m = 1'b1; wq(1);
        scl_m = 1'b1; wq(1);
        sda_m = 1'b0; wq(1);
        scl_m = 1'b0; wq(1);
    endtask

    task automatic do_stop();
        sda_m = 1'b0; wq(1);
        scl_m = 1'b1; wq(1);
        sda_m = 1'b1; wq(2);
    endtask

    task automatic send_addr(input logic [7:0] b, output logic ack_bit);
        logic r;
        for (int i = 7; i >= 0; i--) bitx(b[i], r);
        bitx(1'b1, ack_bit);
    endtask

    task automatic read_byte(input logic ack, output logic [7:0] d);
        logic r;
        d = '0;
        for (int i = 0; i < 8; i++) begin
            bitx(1'b1, r);
            d = {d[6:0], r};
        end
        bitx(~ack, r);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic       a;
        logic [7:0] d;
        int e0, b0, d0, p0;
        for (int i = 0; i < 8; i++) mem[i] = 8'h00;

        // R1 reset state
        repeat (5) @(negedge clk);
        chk("R1 oe in reset", int'(sda_oe), 0);
        chk("R1 events in reset", int'({evt_done, evt_abort, evt_err}), 0);
        rst_n = 1'b1;
        repeat (8) @(negedge clk);
        chk("R1 oe after reset", int'(sda_oe), 0);
        chk("R1 rdy after reset", int'(tx_rdy), 0);

        // sweep with tx_ready low: R4 R5 R6
        tx_ready = 1'b0; nbytes = 0; idx = 0;
        for (int ad = 0; ad < 128; ad++) begin
            for (int rw = 0; rw < 2; rw++) begin
                e0 = n_err;
                do_start();
                send_addr({ad[6:0], rw[0]}, a);
                do_stop();
                chk("R4 R5 R6 no ack when not ready", int'(a), 1);
                chk("R5 error pulse count", n_err - e0,
                    (ad == int'(OWN) && rw == 1) ? 1 : 0);
            end
        end

        // sweep with tx_ready high and empty source: R3 R4 R6 R11
        tx_ready = 1'b1;
        for (int ad = 0; ad < 128; ad++) begin
            for (int rw = 0; rw < 2; rw++) begin
                e0 = n_err; b0 = n_abort;
                do_start();
                send_addr({ad[6:0], rw[0]}, a);
                chk("R3 R4 R6 ack decision", int'(a),
                    (ad == int'(OWN) && rw == 1) ? 0 : 1);
                if (!a) begin
                    read_byte(1'b0, d);
                    chk("R11 fill byte on empty source", int'(d), 8'hFF);
                end
                do_stop();
                chk("R4 R11 no error/abort", (n_err - e0) + (n_abort - b0), 0);
            end
        end

        // buffer of three, last flagged, then one extra read: R7 R8 R10 R11
        mem[0] = 8'hA5; mem[1] = 8'h3C; mem[2] = 8'h01;
        nbytes = 3; idx = 0; last_en = 1'b1;
        d0 = n_done; b0 = n_abort; p0 = n_pop;
        do_start();
        send_addr({OWN, 1'b1}, a);
        chk("R3 ack on ready read", int'(a), 0);
        read_byte(1'b1, d); chk("R7 byte0", int'(d), 8'hA5);
        read_byte(1'b1, d); chk("R7 byte1", int'(d), 8'h3C);
        read_byte(1'b1, d); chk("R7 byte2", int'(d), 8'h01);
        chk("R10 done after last ack", n_done - d0, 1);
        chk("R8 pops for buffer", n_pop - p0, 3);
        read_byte(1'b0, d); chk("R11 fill after last", int'(d), 8'hFF);
        do_stop();
        chk("R11 no abort on fill nack", n_abort - b0, 0);
        chk("R8 no pop after last", n_pop - p0, 3);

        // master NACK on a real byte: R9
        mem[0] = 8'h81; mem[1] = 8'h7E; nbytes = 2; idx = 0;
        b0 = n_abort; d0 = n_done;
        do_start();
        send_addr({OWN, 1'b1}, a);
        read_byte(1'b0, d); chk("R9 byte before nack", int'(d), 8'h81);
        chk("R9 abort pulse", n_abort - b0, 1);
        read_byte(1'b1, d); chk("R9 released after abort", int'(d), 8'hFF);
        do_stop();
        chk("R9 no done", n_done - d0, 0);

        // source runs dry without last flag: R11
        mem[0] = 8'hC3; nbytes = 1; idx = 0; last_en = 1'b0;
        b0 = n_abort; d0 = n_done; p0 = n_pop;
        do_start();
        send_addr({OWN, 1'b1}, a);
        read_byte(1'b1, d); chk("R11 real byte", int'(d), 8'hC3);
        read_byte(1'b1, d); chk("R11 fill 1", int'(d), 8'hFF);
        read_byte(1'b0, d); chk("R11 fill 2", int'(d), 8'hFF);
        do_stop();
        chk("R11 no abort or done", (n_abort - b0) + (n_done - d0), 0);
        chk("R8 one pop when dry", n_pop - p0, 1);
        last_en = 1'b1;

        // masking: R12
        evt_mask = 3'b000; tx_ready = 1'b0; e0 = n_err;
        do_start(); send_addr({OWN, 1'b1}, a); do_stop();
        chk("R12 masked error still nacks", int'(a), 1);
        chk("R12 masked error suppressed", n_err - e0, 0);
        evt_mask = 3'b100; e0 = n_err;
        do_start(); send_addr({OWN, 1'b1}, a); do_stop();
        chk("R12 error enabled", n_err - e0, 1);
        tx_ready = 1'b1; mem[0] = 8'h11; nbytes = 1; idx = 0; b0 = n_abort;
        do_start(); send_addr({OWN, 1'b1}, a);
        read_byte(1'b0, d); do_stop();
        chk("R12 abort masked data", int'(d), 8'h11);
        chk("R12 abort masked", n_abort - b0, 0);
        evt_mask = 3'b111;

        // repeated start mid-address: R2
        mem[0] = 8'h5A; nbytes = 1; idx = 0; d0 = n_done;
        do_start();
        for (int i = 0; i < 4; i++) bitx(1'b0, a);
        do_start();
        send_addr({OWN, 1'b1}, a);
        chk("R2 ack after repeated start", int'(a), 0);
        read_byte(1'b1, d);
        chk("R2 data after repeated start", int'(d), 8'h5A);
        do_stop();
        chk("R2 R10 done after repeated start", n_done - d0, 1);

        // stop mid-address, then clock address without start: R2
        do_start();
        for (int i = 0; i < 3; i++) bitx(1'b1, a);
        do_stop();
        send_addr({OWN, 1'b1}, a);
        chk("R2 no ack without start", int'(a), 1);
        do_stop();

        chk("R7 oe changed only with SCL low", n_oe_bad, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule